// File: doc/BRIEF.md
# Pulsed radar frame sequencer

This block produces the repeating timing frame of a monostatic pulsed radar. A frame walks through four phases in a fixed order. The first is transmit-on, when the waveform generator is keyed. Next comes a switching gap for the transmit/receive switch. Then a receive look window opens, when echo samples are captured, and last there is an idle gap before the next pulse. Each phase has its own programmable length. The block raises a transmit-enable during the on phase, a receive-capture enable during the look window, and a one-clock pulse at the start of every frame.

Two further outputs drive the antenna transmit/receive switch. Each one is a copy of the transmit-enable or of the receive-enable, shifted later by its own programmable number of clocks. That gives the switch time to settle around the pulse and around the listening window.

All settings arrive through a small write-only register bus with a one-clock strobe. A hold bit in the mode register keeps the sequencer stopped. Clearing the hold bit starts a fresh frame at transmit-on.

Top module: `pulse_frame_seq`

## Requirements
- R1: A write is captured on the rising clock edge where `cfg_we` is high. Address 0 holds the hold bit in data bit 0. Addresses 1 to 4 hold the lengths of the on, switching, look and idle phases in data bits 23:0. Address 5 holds the transmit switch delay in bits 31:16 and the receive switch delay in bits 15:0. A write to any other address changes nothing.
- R2: After `rst_n` is asserted, the hold bit is 1, all lengths and delays are 0, and every output is 0.
- R3: While running, the phases follow the order on, switching, look, idle, then on again. `phase_oh` shows the current phase: bit 0 for on, bit 1 for switching, bit 2 for look and bit 3 for idle. It reads 0 while held.
- R4: A phase whose programmed length is N lasts N+1 clocks, so one frame lasts the sum of the four lengths plus 4 clocks.
- R5: `tx_en` is high exactly during the on phase and `rx_en` is high exactly during the look phase.
- R6: `frame_start` is high for one clock, in the first cycle of each on phase.
- R7: If the hold bit is cleared by a write captured at edge W, the first on cycle is the cycle that begins at edge W+1.
- R8: A length written while running is first used when that phase is next entered. A write captured on the same edge on which the phase is entered does not affect that entry.
- R9: `ant_tx` equals `tx_en` delayed by the transmit delay in clocks; a delay of 0 makes it follow `tx_en` directly. The delay must be shorter than one frame.
- R10: `ant_rx` equals `rx_en` delayed by the receive delay in clocks, under the same rule.
- R11: If the hold bit is set by a write captured at edge W, then from the cycle after edge W+1 `phase_oh`, all enables, `ant_tx` and `ant_rx` are 0. Any delayed switch edges still waiting are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_addr | input | 7 | Register address |
| cfg_data | input | 32 | Register write data |
| cfg_we | input | 1 | Write strobe, one clock per write |
| phase_oh | output | 4 | One-hot current phase, 0 while held |
| tx_en | output | 1 | Transmit enable (on phase) |
| rx_en | output | 1 | Receive capture enable (look phase) |
| frame_start | output | 1 | One-clock pulse at start of each frame |
| ant_tx | output | 1 | Delayed transmit antenna-switch control |
| ant_rx | output | 1 | Delayed receive antenna-switch control |

## Verification
The sharpest collision is a length write that lands on the same edge on which that phase is entered. The bench counts cycles from a frame-start pulse and raises the strobe in the final idle cycle. The on phase then entered must keep its old length, and the frame after it must show the new length. A second collision is a hold write while delayed antenna edges are still pending, with both a rise and a fall in flight because the delay exceeds the phase length. The bench judges this against a behavioural model that runs every clock and against direct checks that the switch outputs drop and stay low.

// File: rtl/pulse_frame_seq.sv
module pulse_frame_seq #(
  parameter int AW        = 7,
  parameter int DW        = 32,
  parameter int TW        = 24,
  parameter int DLYW      = 16,
  parameter int ADDR_MODE = 0,
  parameter int ADDR_DUR0 = 1,
  parameter int ADDR_DLY  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_data,
  input  logic          cfg_we,
  output logic [3:0]    phase_oh,
  output logic          tx_en,
  output logic          rx_en,
  output logic          frame_start,
  output logic          ant_tx,
  output logic          ant_rx
);

  localparam int NPH = 4;

  typedef enum logic [2:0] {S_ON = 3'd0, S_SW = 3'd1, S_LOOK = 3'd2, S_IDLE = 3'd3, S_HALT = 3'd4} st_t;

  logic            hold;
  logic [TW-1:0]   dur [NPH];
  logic [DLYW-1:0] dtx, drx;
  st_t             st, st_n;
  logic [TW-1:0]   cnt, cnt_n;
  logic [1:0]      nph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b1;
      for (int i = 0; i < NPH; i++) dur[i] <= '0;
      dtx  <= '0;
      drx  <= '0;
    end else if (cfg_we) begin
      if (int'(cfg_addr) == ADDR_MODE) hold <= cfg_data[0];
      for (int i = 0; i < NPH; i++)
        if (int'(cfg_addr) == ADDR_DUR0 + i) dur[i] <= cfg_data[TW-1:0];
      if (int'(cfg_addr) == ADDR_DLY) {dtx, drx} <= cfg_data[2*DLYW-1:0];
    end
  end

  assign nph = st[1:0] + 2'd1;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (hold) begin
      st_n  = S_HALT;
      cnt_n = '0;
    end else if (st == S_HALT) begin
      st_n  = S_ON;
      cnt_n = dur[0];
    end else if (cnt == '0) begin
      st_n  = st_t'({1'b0, nph});
      cnt_n = dur[nph];
    end else begin
      cnt_n = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_HALT;
      cnt         <= '0;
      frame_start <= 1'b0;
    end else begin
      st          <= st_n;
      cnt         <= cnt_n;
      frame_start <= (st_n == S_ON) && (st != S_ON);
    end
  end

  assign phase_oh = (st == S_HALT) ? 4'b0000 : (4'b0001 << st[1:0]);
  assign tx_en    = phase_oh[0];
  assign rx_en    = phase_oh[2];

  logic [1:0]      en_now, en_nxt, ant;
  logic [DLYW-1:0] dsel [2];

  assign en_now  = {rx_en, tx_en};
  assign en_nxt  = {st_n == S_LOOK, st_n == S_ON};
  assign dsel[0] = dtx;
  assign dsel[1] = drx;

  for (genvar g = 0; g < 2; g++) begin : g_ant
    logic            rp, fp, aq;
    logic [DLYW-1:0] rc, fc;
    logic            rise, fall, zero, set_e, clr_e;

    assign rise  = en_nxt[g] & ~en_now[g];
    assign fall  = ~en_nxt[g] & en_now[g];
    assign zero  = (dsel[g] == '0);
    assign set_e = (rise && zero) || (rp && rc == DLYW'(1));
    assign clr_e = (fall && zero) || (fp && fc == DLYW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rp <= 1'b0; fp <= 1'b0; rc <= '0; fc <= '0; aq <= 1'b0;
      end else if (hold) begin
        rp <= 1'b0; fp <= 1'b0; aq <= 1'b0;
      end else begin
        aq <= clr_e ? 1'b0 : (set_e ? 1'b1 : aq);
        if (rise && !zero) begin
          rp <= 1'b1; rc <= dsel[g];
        end else if (rp) begin
          if (rc == DLYW'(1)) rp <= 1'b0;
          rc <= rc - 1'b1;
        end
        if (fall && !zero) begin
          fp <= 1'b1; fc <= dsel[g];
        end else if (fp) begin
          if (fc == DLYW'(1)) fp <= 1'b0;
          fc <= fc - 1'b1;
        end
      end
    end

    assign ant[g] = aq;
  end

  assign ant_tx = ant[0];
  assign ant_rx = ant[1];

  a_r5_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && rx_en));

  a_r6_start_on_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (tx_en && !$past(tx_en)));

  a_r3_switch_after_on: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_en) && !tx_en && !$past(hold)) |-> (phase_oh == 4'b0010));

  a_r4_phase_held_while_counting: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && st != S_HALT && !hold) |=> $stable(phase_oh));

  a_r7_start_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st == S_HALT) && !$past(hold)) |-> frame_start);

  a_r11_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> (phase_oh == 4'b0000 && !ant_tx && !ant_rx));

endmodule

// File: tb/test_pulse_frame_seq.sv
`timescale 1ns/1ps
module test_pulse_frame_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  phase_oh;
  logic        tx_en, rx_en, frame_start, ant_tx, ant_rx;

  int n_chk = 0;
  int n_bad = 0;

  pulse_frame_seq i_pulse_frame_seq (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_we(cfg_we),
    .phase_oh(phase_oh), .tx_en(tx_en), .rx_en(rx_en), .frame_start(frame_start),
    .ant_tx(ant_tx), .ant_rx(ant_rx));

  always #2 clk = ~clk;

  int m_hold, m_ph, m_rem, m_fs, m_dtx, m_drx, t, last_halt;
  int m_dur [4];
  bit htx [256];
  bit hrx [256];
  logic [3:0] e_ph;
  bit e_atx, e_arx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold = 1; m_ph = -1; m_rem = 0; m_fs = 0; m_dtx = 0; m_drx = 0;
      t = 0; last_halt = 0;
      for (int i = 0; i < 4; i++) m_dur[i] = 0;
      for (int i = 0; i < 256; i++) begin htx[i] = 0; hrx[i] = 0; end
    end else begin
      int old;
      old = m_ph;
      if (m_hold != 0) m_ph = -1;
      else if (m_ph == -1) begin m_ph = 0; m_rem = m_dur[0]; end
      else if (m_rem == 0) begin m_ph = (m_ph + 1) % 4; m_rem = m_dur[m_ph]; end
      else m_rem = m_rem - 1;
      m_fs = (m_ph == 0 && old != 0) ? 1 : 0;
      if (cfg_we) begin
        if (cfg_addr == 0) m_hold = int'(cfg_data[0]);
        else if (cfg_addr >= 1 && cfg_addr <= 4) m_dur[cfg_addr - 1] = int'(cfg_data[23:0]);
        else if (cfg_addr == 5) begin m_dtx = int'(cfg_data[31:16]); m_drx = int'(cfg_data[15:0]); end
      end
      t = t + 1;
      htx[t % 256] = (m_ph == 0);
      hrx[t % 256] = (m_ph == 2);
      if (m_ph == -1) last_halt = t;
    end
    e_ph  = (m_ph < 0) ? 4'b0000 : (4'b0001 << m_ph);
    e_atx = (last_halt < t - m_dtx) ? htx[(t - m_dtx) % 256] : 1'b0;
    e_arx = (last_halt < t - m_drx) ? hrx[(t - m_drx) % 256] : 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (phase_oh !== e_ph) begin n_bad++; $display("FAIL R3 phase act=%b exp=%b", phase_oh, e_ph); end
      if (tx_en !== e_ph[0] || rx_en !== e_ph[2]) begin
        n_bad++; $display("FAIL R5 enables act=%b%b exp=%b%b", tx_en, rx_en, e_ph[0], e_ph[2]);
      end
      if (frame_start !== m_fs[0]) begin n_bad++; $display("FAIL R6 frame_start act=%b exp=%b", frame_start, m_fs[0]); end
      if (ant_tx !== e_atx) begin n_bad++; $display("FAIL R9 ant_tx act=%b exp=%b", ant_tx, e_atx); end
      if (ant_rx !== e_arx) begin n_bad++; $display("FAIL R10 ant_rx act=%b exp=%b", ant_rx, e_arx); end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin n_bad++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
  endtask

  task automatic cfg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = 7'(a); cfg_data = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start);
  endtask

  task automatic run_len_tx(output int n);
    n = 0;
    while (tx_en) begin n++; @(negedge clk); end
  endtask

  task automatic run_len_rx(output int n);
    n = 0;
    while (rx_en) begin n++; @(negedge clk); end
  endtask

  task automatic period(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_start);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 outputs after reset", int'({phase_oh, tx_en, rx_en, frame_start, ant_tx, ant_rx}), 0);

    // R1 programming, R7 start latency
    cfg_write(1, 32'd3);
    cfg_write(2, 32'd1);
    cfg_write(3, 32'd4);
    cfg_write(4, 32'd2);
    cfg_write(5, 32'h0002_0003);
    repeat (3) @(negedge clk);
    check("R2 still held", int'(phase_oh), 0);
    cfg_write(0, 32'd0);
    check("R7 no on one cycle after release", int'(tx_en), 0);
    @(negedge clk);
    check("R7 on begins at next edge", int'(tx_en), 1);
    check("R6 start pulse at release", int'(frame_start), 1);
    run_len_tx(n);
    check("R4 on length 3+1", n, 4);
    wait_fs();
    period(n);
    check("R4 frame length 14", n, 14);

    // R8 write landing on the entry edge
    repeat (12) @(negedge clk);
    cfg_write(1, 32'd6);
    check("R6 entry after collision write", int'(frame_start), 1);
    run_len_tx(n);
    check("R8 same-edge write ignored for this entry", n, 4);
    wait_fs();
    run_len_tx(n);
    check("R8 new on length next frame", n, 7);

    // R8 write in the middle of look
    do @(negedge clk); while (!rx_en);
    cfg_write(3, 32'd9);
    run_len_rx(n);
    check("R8 current look unchanged", n, 3);
    do @(negedge clk); while (!rx_en);
    run_len_rx(n);
    check("R8 next look uses new length", n, 10);

    // R1 unused address ignored
    cfg_write(9, 32'hFFFF_FFFF);
    wait_fs();
    period(n);
    check("R1 unmapped write ignored", n, 22);

    // R11 hold with pending switch edges (rx delay exceeds look)
    cfg_write(0, 32'd1);
    cfg_write(5, 32'h0000_000C);
    cfg_write(0, 32'd0);
    repeat (60) @(negedge clk);
    do @(negedge clk); while (!rx_en);
    repeat (10) @(negedge clk);
    cfg_write(0, 32'd1);
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      check("R11 held outputs quiet", int'({phase_oh, ant_tx, ant_rx}), 0);
      @(negedge clk);
    end

    // R9 zero delay follows tx_en
    cfg_write(0, 32'd0);
    wait_fs();
    check("R9 zero delay tracks tx_en", int'(ant_tx), 1);
    repeat (200) @(negedge clk);

    // R9 R10 longer delays, larger phases
    cfg_write(0, 32'd1);
    cfg_write(1, 32'd40);
    cfg_write(2, 32'd5);
    cfg_write(3, 32'd60);
    cfg_write(4, 32'd100);
    cfg_write(5, 32'h0011_0007);
    cfg_write(0, 32'd0);
    wait_fs();
    n = 0;
    while (!ant_tx) begin @(negedge clk); n++; end
    check("R9 tx switch delay 17", n, 17);
    do @(negedge clk); while (!rx_en);
    n = 0;
    while (!ant_rx) begin @(negedge clk); n++; end
    check("R10 rx switch delay 7", n, 7);
    wait_fs();
    period(n);
    check("R4 frame length 209", n, 209);
    repeat (1500) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule